// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit turns the operand-addressing bytes of an instruction into an operand location. A request carries the addressing byte (mode field in bits 7:6, register-or-memory field in bits 2:0), the scale/index/base byte, the displacement bytes that follow them, the address-size mode, and a snapshot of the eight general registers and the segment values. One cycle later the unit reports one of two results. For a register operand it gives the register number. For a memory operand it gives the effective offset, the linear address and the segment choice.

It also reports how many bytes after the addressing byte the operand form used, from 0 to 5, so that a fetch stage can advance its instruction pointer. Both the irregular 16-bit base/index table and the 32-bit forms are covered, including scaled indexing and the base-less special cases. Fetching bytes, protection checks and limit checks are left to other units.

Top module: `eagen_core`

## Requirements
- R1: When the mode field equals 3, the result is a register operand: `is_reg`=1, `reg_sel` equals bits 2:0 of the addressing byte, and `extra_len`, `eff_off`, `lin_addr` and `seg_is_ss` are all 0.
- R2: In 16-bit mode, the register-or-memory values 0 to 7 select BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX. Register numbers are AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6, DI=7, and register n sits in `gpr_flat[32n+31:32n]`.
- R3: In 16-bit mode, with mode field 0 and register-or-memory 6, the offset is `disp[15:0]` alone and `extra_len` is 2.
- R4: With mode field 1, the byte `disp[7:0]` is sign-extended and added, and it adds 1 to `extra_len`. This holds in both address sizes.
- R5: With mode field 2, `disp[15:0]` is added in 16-bit mode, where `extra_len` is 2 and the upper displacement bytes are ignored. In 32-bit mode `disp[31:0]` is added, and it adds 4 to `extra_len`.
- R6: In 16-bit mode the effective offset wraps modulo 2^16, so `eff_off[31:16]` is 0.
- R7: In 32-bit mode without a scale/index/base byte, the register-or-memory field names the 32-bit base register. The exception is mode field 0 with register-or-memory 5: there the offset is `disp[31:0]` alone and `extra_len` is 4.
- R8: In 32-bit mode, register-or-memory 4 means the scale/index/base byte is used, and it adds 1 to `extra_len`. The offset is base (bits 2:0) plus index (bits 5:3) shifted left by scale (bits 7:6). An index value of 4 means no index.
- R9: In 32-bit mode, with mode field 0 and a base value of 5 in the scale/index/base byte, `disp[31:0]` replaces the base register and `extra_len` is 5.
- R10: Without an override, a memory operand uses SS when its base is BP, EBP or ESP, and `seg_is_ss`=1 in that case. Otherwise it uses DS. When `seg_ovr_en`=1, `seg_ovr` is used instead and `seg_is_ss`=0.
- R11: `lin_addr` equals the chosen segment value times 16 plus `eff_off`, modulo 2^32.
- R12: Results appear with `res_valid`=1 on the cycle after a request is sampled. `res_valid` is 0 after a cycle without a request. Reset clears `res_valid` and every result output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| addr32 | input | 1 | 1 selects 32-bit addressing, 0 selects 16-bit addressing |
| modrm | input | 8 | Addressing byte |
| sib | input | 8 | Scale/index/base byte (used only in 32-bit mode with register-or-memory 4) |
| disp | input | 32 | Displacement bytes, little-endian, starting at the first byte after the addressing bytes |
| gpr_flat | input | 256 | Eight 32-bit general registers, register n in bits 32n+31:32n |
| seg_ds | input | 16 | Default data segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ovr_en | input | 1 | Use `seg_ovr` instead of the default segment |
| seg_ovr | input | 16 | Override segment value |
| res_valid | output | 1 | Result valid |
| is_reg | output | 1 | Operand is a register |
| reg_sel | output | 3 | Register number for a register operand |
| eff_off | output | 32 | Effective offset |
| lin_addr | output | 32 | Segment times 16 plus offset |
| extra_len | output | 3 | Bytes used after the addressing byte |
| seg_is_ss | output | 1 | The default stack segment was chosen |

## Verification
The vector table covers every mode-field value in both address sizes, so each decoder is tried with no displacement, a short displacement and a long displacement. Negative short displacements show whether sign extension is applied, and a 16-bit BP+DI sum beyond 0xFFFF shows whether the wrap is applied. In the scaled-index cases, each vector pairs its own scale with its own base and index registers, which tells apart a wrong shift, a wrong field and a missing "no index" or "displacement replaces base" rule. Some cases choose ESP, EBP or BP as the base, with and without an override, which tells the segment choice apart from the offset path. Directed steps then check the idle cycle and reset.

// File: rtl/eagen_pkg.sv
// Package: shared constants, result type and helpers for the operand
// effective address generator. Assumes the standard register numbering
// (0=AX .. 7=DI), which the address forms depend on.
package eagen_pkg;
    localparam int GPR_N   = 8;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int SEG_W   = 16;
    localparam int LEN_W   = 3;

    localparam logic [1:0] MOD_NODISP = 2'd0;
    localparam logic [1:0] MOD_DISP8  = 2'd1;
    localparam logic [1:0] MOD_DISPW  = 2'd2;
    localparam logic [1:0] MOD_REG    = 2'd3;

    localparam logic [2:0] R_SP       = 3'd4;
    localparam logic [2:0] R_BP       = 3'd5;
    localparam logic [2:0] RM_SIB     = 3'd4;
    localparam logic [2:0] RM_ABS32   = 3'd5;
    localparam logic [2:0] RM_ABS16   = 3'd6;
    localparam logic [2:0] IDX_NONE   = 3'd4;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t             off;
        logic [LEN_W-1:0]  len;
        logic              ss_dflt;
    } ea_res_t;

    function automatic word_t sext8(input logic [7:0] b);
        return {{(WORD_W-8){b[7]}}, b};
    endfunction
endpackage

// File: rtl/eagen_dec16.sv
// Module: 16-bit form decoder. Combinational. Forms base+index+displacement
// from the fixed 16-bit table and wraps the sum to 16 bits. Assumes the
// mode field is not 3 (the top handles register operands).
module eagen_dec16
    import eagen_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [2:0]        rm,
    input  logic [15:0]       disp16,
    input  logic [HALF_W-1:0] bx,
    input  logic [HALF_W-1:0] bp,
    input  logic [HALF_W-1:0] si,
    input  logic [HALF_W-1:0] di,
    output ea_res_t           res
);
    logic [HALF_W-1:0] term_a;
    logic [HALF_W-1:0] term_b;
    logic [HALF_W-1:0] term_d;
    logic [HALF_W-1:0] sum16;
    logic              abs_form;

    assign abs_form = (mode == MOD_NODISP) && (rm == RM_ABS16);

    // Pick the two register terms of the irregular table.
    always_comb begin
        term_a = '0;
        term_b = '0;
        unique case (rm)
            3'd0: begin term_a = bx; term_b = si; end
            3'd1: begin term_a = bx; term_b = di; end
            3'd2: begin term_a = bp; term_b = si; end
            3'd3: begin term_a = bp; term_b = di; end
            3'd4: term_a = si;
            3'd5: term_a = di;
            3'd6: term_a = abs_form ? '0 : bp;
            3'd7: term_a = bx;
        endcase
    end

    // Displacement value and length chosen by the mode field.
    always_comb begin
        term_d  = '0;
        res.len = '0;
        unique case (mode)
            MOD_NODISP: begin
                term_d  = abs_form ? disp16 : '0;
                res.len = abs_form ? LEN_W'(2) : LEN_W'(0);
            end
            MOD_DISP8: begin
                term_d  = {{8{disp16[7]}}, disp16[7:0]};
                res.len = LEN_W'(1);
            end
            MOD_DISPW: begin
                term_d  = disp16;
                res.len = LEN_W'(2);
            end
            default: begin
                term_d  = '0;
                res.len = '0;
            end
        endcase
    end

    // Sum modulo 2^16 and the stack-segment default for BP-based forms.
    always_comb begin
        sum16       = term_a + term_b + term_d;
        res.off     = {{(WORD_W-HALF_W){1'b0}}, sum16};
        res.ss_dflt = (rm == 3'd2) || (rm == 3'd3) || ((rm == 3'd6) && !abs_form);
    end
endmodule

// File: rtl/eagen_dec32.sv
// Module: 32-bit form decoder. Combinational. Handles a plain base register,
// the absolute displacement form and the scaled-index byte, including
// "no index" and "displacement replaces base". Assumes mode field is not 3.
module eagen_dec32
    import eagen_pkg::*;
(
    input  logic [1:0]                    mode,
    input  logic [2:0]                    rm,
    input  logic [7:0]                    sib,
    input  word_t                         disp,
    input  logic [GPR_N-1:0][WORD_W-1:0]  gpr,
    output ea_res_t                       res
);
    logic       use_sib;
    logic [1:0] scale;
    logic [2:0] idx;
    logic [2:0] base;
    logic       no_base;
    logic [2:0] base_num;
    word_t      base_v;
    word_t      idx_v;
    word_t      disp_v;
    logic [LEN_W-1:0] disp_len;

    assign use_sib = (rm == RM_SIB);
    assign scale   = sib[7:6];
    assign idx     = sib[5:3];
    assign base    = sib[2:0];

    // Decide which register (if any) serves as base.
    always_comb begin
        base_num = use_sib ? base : rm;
        no_base  = (mode == MOD_NODISP) &&
                   (use_sib ? (base == R_BP) : (rm == RM_ABS32));
        base_v   = no_base ? '0 : gpr[base_num];
    end

    // Scaled index term; absent without the extra byte or for index 4.
    always_comb begin
        idx_v = '0;
        if (use_sib && (idx != IDX_NONE)) begin
            unique case (scale)
                2'd0: idx_v = gpr[idx];
                2'd1: idx_v = gpr[idx] << 1;
                2'd2: idx_v = gpr[idx] << 2;
                2'd3: idx_v = gpr[idx] << 3;
            endcase
        end
    end

    // Displacement value and its byte count from mode field and base-less case.
    always_comb begin
        disp_v   = '0;
        disp_len = '0;
        unique case (mode)
            MOD_DISP8: begin
                disp_v   = sext8(disp[7:0]);
                disp_len = LEN_W'(1);
            end
            MOD_DISPW: begin
                disp_v   = disp;
                disp_len = LEN_W'(4);
            end
            default: begin
                disp_v   = no_base ? disp : '0;
                disp_len = no_base ? LEN_W'(4) : LEN_W'(0);
            end
        endcase
    end

    // Final sum, length and stack-segment default (ESP or EBP as base).
    always_comb begin
        res.off     = base_v + idx_v + disp_v;
        res.len     = disp_len + (use_sib ? LEN_W'(1) : LEN_W'(0));
        res.ss_dflt = !no_base && ((base_num == R_SP) || (base_num == R_BP));
    end
endmodule

// File: rtl/eagen_core.sv
// Module: top of the operand effective address generator. Unpacks the
// register snapshot, runs both form decoders, selects by address size,
// picks the segment and forms the linear address, then registers the
// result one cycle after a request. Assumes inputs are stable in the
// request cycle only; outputs hold until the next request.
module eagen_core
    import eagen_pkg::*;
#(
    parameter int LIN_W     = 32,
    parameter int SEG_SHIFT = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     addr32,
    input  logic [7:0]               modrm,
    input  logic [7:0]               sib,
    input  logic [WORD_W-1:0]        disp,
    input  logic [GPR_N*WORD_W-1:0]  gpr_flat,
    input  logic [SEG_W-1:0]         seg_ds,
    input  logic [SEG_W-1:0]         seg_ss,
    input  logic                     seg_ovr_en,
    input  logic [SEG_W-1:0]         seg_ovr,
    output logic                     res_valid,
    output logic                     is_reg,
    output logic [2:0]               reg_sel,
    output logic [WORD_W-1:0]        eff_off,
    output logic [LIN_W-1:0]         lin_addr,
    output logic [LEN_W-1:0]         extra_len,
    output logic                     seg_is_ss
);
    localparam int SEG_X_W = SEG_W + SEG_SHIFT;

    logic [GPR_N-1:0][WORD_W-1:0] gpr_v;
    logic [1:0]       mode;
    logic [2:0]       rm;
    logic             reg_form;
    ea_res_t          res16;
    ea_res_t          res32;
    ea_res_t          res_sel;
    logic [SEG_W-1:0] seg_val;
    logic             ss_pick;
    logic [LIN_W-1:0] lin_nxt;

    // Split the flat register snapshot into words.
    for (genvar g = 0; g < GPR_N; g++) begin : g_unpack
        assign gpr_v[g] = gpr_flat[g*WORD_W +: WORD_W];
    end

    assign mode     = modrm[7:6];
    assign rm       = modrm[2:0];
    assign reg_form = (mode == MOD_REG);

    eagen_dec16 u_dec16 (
        .mode   (mode),
        .rm     (rm),
        .disp16 (disp[15:0]),
        .bx     (gpr_v[3][HALF_W-1:0]),
        .bp     (gpr_v[5][HALF_W-1:0]),
        .si     (gpr_v[6][HALF_W-1:0]),
        .di     (gpr_v[7][HALF_W-1:0]),
        .res    (res16)
    );

    eagen_dec32 u_dec32 (
        .mode (mode),
        .rm   (rm),
        .sib  (sib),
        .disp (disp),
        .gpr  (gpr_v),
        .res  (res32)
    );

    // Address-size select, segment choice and linear address.
    always_comb begin
        res_sel = addr32 ? res32 : res16;
        ss_pick = !seg_ovr_en && res_sel.ss_dflt;
        seg_val = seg_ovr_en ? seg_ovr : (res_sel.ss_dflt ? seg_ss : seg_ds);
        lin_nxt = LIN_W'({{(LIN_W > SEG_X_W ? 1 : 1){1'b0}}, seg_val, {SEG_SHIFT{1'b0}}})
                + LIN_W'(res_sel.off);
    end

    // Result register: capture on request, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            is_reg    <= 1'b0;
            reg_sel   <= '0;
            eff_off   <= '0;
            lin_addr  <= '0;
            extra_len <= '0;
            seg_is_ss <= 1'b0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                is_reg    <= reg_form;
                reg_sel   <= reg_form ? rm : 3'd0;
                eff_off   <= reg_form ? '0 : res_sel.off;
                lin_addr  <= reg_form ? '0 : lin_nxt;
                extra_len <= reg_form ? '0 : res_sel.len;
                seg_is_ss <= reg_form ? 1'b0 : ss_pick;
            end
        end
    end
endmodule

// File: rtl/eagen_chk.sv
// Module: property checker for eagen_core, attached by bind. Observes the
// request side and the registered result; drives nothing.
module eagen_chk
    import eagen_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              addr32,
    input logic              res_valid,
    input logic              is_reg,
    input logic [WORD_W-1:0] eff_off,
    input logic [LEN_W-1:0]  extra_len,
    input logic              seg_is_ss
);
    a_r12_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    a_r12_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    a_r1_reg_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && is_reg) |-> (extra_len == '0 && eff_off == '0 && !seg_is_ss));

    a_r6_wrap16: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !addr32) |=> (eff_off[31:16] == 16'h0));

    a_r3_len16_max: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !addr32) |=> (extra_len <= LEN_W'(2)));

    a_r9_len_max: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (extra_len <= LEN_W'(5)));
endmodule

bind eagen_core eagen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .addr32    (addr32),
    .res_valid (res_valid),
    .is_reg    (is_reg),
    .eff_off   (eff_off),
    .extra_len (extra_len),
    .seg_is_ss (seg_is_ss)
);

// File: tb/eagen_core_tb.sv
module eagen_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 17;

    typedef struct packed {
        logic        a32;
        logic [7:0]  modrm;
        logic [7:0]  sib;
        logic [31:0] disp;
        logic        ovr;
        logic        x_reg;
        logic [2:0]  x_rsel;
        logic [31:0] x_off;
        logic [2:0]  x_len;
        logic        x_ss;
    } vec_t;

    // Registers: EAX 1000, ECX 200, EDX 30000, EBX 1234, ESP 8000, EBP F000, ESI 456, EDI FFF0
    localparam vec_t TBL [N_VEC] = '{
        '{1'b0, 8'hC3, 8'h00, 32'h0,        1'b0, 1'b1, 3'd3, 32'h0,        3'd0, 1'b0}, // R1 16-bit register
        '{1'b0, 8'h00, 8'h00, 32'h0,        1'b0, 1'b0, 3'd0, 32'h0000168A, 3'd0, 1'b0}, // R2 BX+SI
        '{1'b0, 8'h03, 8'h00, 32'h0,        1'b0, 1'b0, 3'd0, 32'h0000EFF0, 3'd0, 1'b1}, // R2 R6 R10 BP+DI wraps
        '{1'b0, 8'h06, 8'h00, 32'h0000ABCD, 1'b0, 1'b0, 3'd0, 32'h0000ABCD, 3'd2, 1'b0}, // R3 direct
        '{1'b0, 8'h46, 8'h00, 32'h00000080, 1'b0, 1'b0, 3'd0, 32'h0000EF80, 3'd1, 1'b1}, // R4 BP-128
        '{1'b0, 8'h87, 8'h00, 32'hFFFF1000, 1'b0, 1'b0, 3'd0, 32'h00002234, 3'd2, 1'b0}, // R5 BX+1000
        '{1'b0, 8'h02, 8'h00, 32'h0,        1'b1, 1'b0, 3'd0, 32'h0000F456, 3'd0, 1'b0}, // R10 override
        '{1'b1, 8'h01, 8'h00, 32'h0,        1'b0, 1'b0, 3'd0, 32'h00000200, 3'd0, 1'b0}, // R7 ECX
        '{1'b1, 8'h05, 8'h00, 32'h12345678, 1'b0, 1'b0, 3'd0, 32'h12345678, 3'd4, 1'b0}, // R7 direct32
        '{1'b1, 8'h45, 8'h00, 32'h000000F0, 1'b0, 1'b0, 3'd0, 32'h0000EFF0, 3'd1, 1'b1}, // R4 R10 EBP-16
        '{1'b1, 8'h82, 8'h00, 32'h00100000, 1'b0, 1'b0, 3'd0, 32'h00130000, 3'd4, 1'b0}, // R5 EDX+disp32
        '{1'b1, 8'h04, 8'hB3, 32'h0,        1'b0, 1'b0, 3'd0, 32'h0000238C, 3'd1, 1'b0}, // R8 EBX+ESI*4
        '{1'b1, 8'h04, 8'hCD, 32'h00010000, 1'b0, 1'b0, 3'd0, 32'h00011000, 3'd5, 1'b0}, // R9 disp32+ECX*8
        '{1'b1, 8'h44, 8'h24, 32'h00000008, 1'b0, 1'b0, 3'd0, 32'h00008008, 3'd2, 1'b1}, // R8 R10 ESP+8 no index
        '{1'b1, 8'h84, 8'h05, 32'hFFFFFFFF, 1'b0, 1'b0, 3'd0, 32'h0000FFFF, 3'd5, 1'b1}, // R5 R8 EBP+EAX-1
        '{1'b1, 8'hC6, 8'h00, 32'h0,        1'b0, 1'b1, 3'd6, 32'h0,        3'd0, 1'b0}, // R1 32-bit register
        '{1'b1, 8'h05, 8'h00, 32'hFFFFFFF0, 1'b0, 1'b0, 3'd0, 32'hFFFFFFF0, 3'd4, 1'b0}  // R11 linear wraps
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic         addr32;
    logic [7:0]   modrm;
    logic [7:0]   sib;
    logic [31:0]  disp;
    logic [255:0] gpr_flat;
    logic [15:0]  seg_ds;
    logic [15:0]  seg_ss;
    logic         seg_ovr_en;
    logic [15:0]  seg_ovr;
    logic         res_valid;
    logic         is_reg;
    logic [2:0]   reg_sel;
    logic [31:0]  eff_off;
    logic [31:0]  lin_addr;
    logic [2:0]   extra_len;
    logic         seg_is_ss;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eagen_core u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr32(addr32),
        .modrm(modrm), .sib(sib), .disp(disp), .gpr_flat(gpr_flat),
        .seg_ds(seg_ds), .seg_ss(seg_ss), .seg_ovr_en(seg_ovr_en), .seg_ovr(seg_ovr),
        .res_valid(res_valid), .is_reg(is_reg), .reg_sel(reg_sel), .eff_off(eff_off),
        .lin_addr(lin_addr), .extra_len(extra_len), .seg_is_ss(seg_is_ss)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic check_all_zero(input string what);
        check({what, " res_valid"}, {31'b0, res_valid}, 32'h0);
        check({what, " is_reg"},    {31'b0, is_reg},    32'h0);
        check({what, " eff_off"},   eff_off,            32'h0);
        check({what, " lin_addr"},  lin_addr,           32'h0);
        check({what, " extra_len"}, {29'b0, extra_len}, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog R12 actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] segv;
        logic [31:0] xlin;
        rst_n      = 1'b0;
        req_valid  = 1'b0;
        addr32     = 1'b0;
        modrm      = 8'h0;
        sib        = 8'h0;
        disp       = 32'h0;
        seg_ds     = 16'h1000;
        seg_ss     = 16'h2000;
        seg_ovr    = 16'h3000;
        seg_ovr_en = 1'b0;
        gpr_flat   = {32'h0000FFF0, 32'h00000456, 32'h0000F000, 32'h00008000,
                      32'h00001234, 32'h00030000, 32'h00000200, 32'h00001000};
        repeat (3) @(negedge clk);
        check_all_zero("R12 reset state");
        rst_n = 1'b1;

        for (int v = 0; v < N_VEC; v++) begin
            @(negedge clk);
            addr32     = TBL[v].a32;
            modrm      = TBL[v].modrm;
            sib        = TBL[v].sib;
            disp       = TBL[v].disp;
            seg_ovr_en = TBL[v].ovr;
            req_valid  = 1'b1;
            @(negedge clk);
            req_valid  = 1'b0;
            segv = TBL[v].ovr ? 16'h3000 : (TBL[v].x_ss ? 16'h2000 : 16'h1000);
            xlin = TBL[v].x_reg ? 32'h0 : ({12'h0, segv, 4'h0} + TBL[v].x_off);
            check($sformatf("vec%0d R12 res_valid", v), {31'b0, res_valid}, 32'h1);
            check($sformatf("vec%0d R1 is_reg", v), {31'b0, is_reg}, {31'b0, TBL[v].x_reg});
            check($sformatf("vec%0d R1 reg_sel", v), {29'b0, reg_sel}, {29'b0, TBL[v].x_rsel});
            check($sformatf("vec%0d offset", v), eff_off, TBL[v].x_off);
            check($sformatf("vec%0d length", v), {29'b0, extra_len}, {29'b0, TBL[v].x_len});
            check($sformatf("vec%0d R10 seg_is_ss", v), {31'b0, seg_is_ss}, {31'b0, TBL[v].x_ss});
            check($sformatf("vec%0d R11 lin_addr", v), lin_addr, xlin);
        end

        // R12: a cycle without a request drops res_valid.
        @(negedge clk);
        check("R12 idle res_valid", {31'b0, res_valid}, 32'h0);

        // R12: reset while a request is present clears everything.
        addr32 = 1'b1; modrm = 8'h05; disp = 32'h12345678; seg_ovr_en = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        check("R12 pre-reset res_valid", {31'b0, res_valid}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        check_all_zero("R12 reset mid-run");
        rst_n = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule